// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block gathers the data bytes of one write session for a single memory page and then programs them into the byte array as one timed internal write cycle. A protocol controller in front of it supplies strobes. The first strobe loads a starting byte address. Further strobes hand over data bytes, one each. A final strobe either commits the session (on STOP) or throws it away (for example on a write-protect rejection or a repeated START).

The page number is captured when the address is loaded, and the in-page offset advances by one with every byte. When the offset passes the end of the page it wraps back to the first byte of the same page, so a long burst replaces its own earlier bytes. A per-offset valid mask records which locations were touched. When the session commits, only those locations are rewritten, and `busy_o` stays high for a parameterised number of clocks. While `busy_o` is high, every strobe is ignored. The array powers up erased, and a registered read port lets the surrounding logic read it.

Top module: `pgwr_engine`

## Requirements
- R1: After reset `busy_o` and `mem_we_o` are 0.
- R2: An address load captures the page number (address bits above the low log2(PAGE_BYTES) bits) and the starting offset (those low bits). Each data byte goes to {page, offset} and the offset then increments. The page never changes within a session, so no byte lands outside the loaded page.
- R3: The offset after PAGE_BYTES-1 is 0 of the same page, and a byte stored at an offset that was already loaded replaces the earlier byte.
- R4: On commit, only loaded offsets are written, with exactly one `mem_we_o` pulse per distinct loaded offset. Every other byte of the array keeps its previous value.
- R5: A commit strobe with at least one byte loaded raises `busy_o` on the clock edge that samples it. `busy_o` then stays high for exactly max(WR_CYCLES, PAGE_BYTES+2) cycles and falls one clock after the internal down-counter reaches zero.
- R6: Every array byte reads 0xFF before it is first written. `rd_data_o` shows the byte at `rd_addr_i` one clock after the address is presented.
- R7: A commit strobe with no byte loaded starts no cycle: `busy_o` stays 0 and no write occurs.
- R8: An abort strobe clears the buffered session, so a later commit writes nothing. Abort takes priority over commit, address load and data strobes in the same cycle.
- R9: Address-load, data, abort and commit strobes that arrive while `busy_o` is high have no effect on the array or on the buffered session.
- R10: All array writes of a cycle are finished before `busy_o` falls, and `mem_we_o` is only ever high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load_i | input | 1 | Load the starting byte address |
| addr_i | input | ADDR_W | Starting byte address |
| byte_valid_i | input | 1 | One data byte is present on byte_i |
| byte_i | input | 8 | Data byte |
| abort_i | input | 1 | Discard the buffered session |
| commit_i | input | 1 | STOP seen: program the buffered bytes |
| rd_addr_i | input | ADDR_W | Read port address |
| rd_data_o | output | 8 | Read port data, one clock latency |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
A table of sessions exercises the main function with several patterns. A one-byte write shows that a single location is written. A short run in mid-page shows that bytes move forward from the offset. A run across the top of a page shows that the offset wraps instead of carrying into the next page. A full-page run and a run longer than the page show that overwriting keeps only the newest byte per offset. After each session the whole array is compared with a bench model, and the write pulses are counted, which catches both stray writes and unmasked writes. Directed tests then cover an empty commit, an abort, and strobes issued while the cycle is running. In the last case a follow-up commit with nothing loaded shows that the ignored strobes left the mask empty.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef logic [7:0] byte_t;

  // Cycle length actually used: long enough for the commit sweep to drain.
  function automatic int unsigned cycles_eff(input int unsigned wr_cycles,
                                             input int unsigned page_bytes);
    return (wr_cycles < page_bytes + 2) ? page_bytes + 2 : wr_cycles;
  endfunction

endpackage

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned WR_CYCLES  = 1000,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic             sweep_en_o,
  output logic [IDX_W-1:0] sweep_idx_o,
  output logic             sweep_last_o
);

  localparam int unsigned EFF   = pgwr_pkg::cycles_eff(WR_CYCLES, PAGE_BYTES);
  localparam int unsigned CNT_W = $clog2(EFF);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             act_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(EFF - 1);
        act_q  <= 1'b1;
        idx_q  <= '0;
      end else begin
        if (busy_q) begin
          if (cnt_q == '0) busy_q <= 1'b0;
          else             cnt_q  <= cnt_q - 1'b1;
        end
        if (act_q) begin
          if (idx_q == LAST_IDX) act_q <= 1'b0;
          else                   idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign sweep_en_o   = act_q;
  assign sweep_idx_o  = idx_q;
  assign sweep_last_o = act_q && (idx_q == LAST_IDX);

  // R5: an accepted start raises busy on that edge
  p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_q) |=> busy_q);
  // R5: busy only falls once the counter has run out
  p_busy_end_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(cnt_q) == '0));
  // R10: sweep runs only inside the busy window
  p_sweep_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    act_q |-> busy_q);

endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
  import pgwr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PAGE_BYTES = 32,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              abort_i,
  input  logic              commit_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  byte_t             byte_i,
  input  logic              sweep_en_i,
  input  logic [IDX_W-1:0]  sweep_idx_i,
  input  logic              sweep_last_i,
  output logic              mask_any_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output byte_t             mem_wdata_o
);

  logic [PAGE_W-1:0]     page_q;
  logic [IDX_W-1:0]      off_q;
  logic [PAGE_BYTES-1:0] mask_q;
  byte_t                 data_q [PAGE_BYTES];

  logic idle;
  logic do_load;
  logic do_byte;

  assign idle    = !busy_i;
  assign do_load = idle && !abort_i && !commit_i && addr_load_i;
  assign do_byte = idle && !abort_i && !commit_i && !addr_load_i && byte_valid_i;

  // Session control: page, offset and valid mask.
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else if (idle) begin
      if (abort_i) begin
        mask_q <= '0;
      end else if (do_load) begin
        page_q <= addr_i[ADDR_W-1:IDX_W];
        off_q  <= addr_i[IDX_W-1:0];
        mask_q <= '0;
      end else if (do_byte) begin
        mask_q[off_q] <= 1'b1;
        off_q         <= off_q + 1'b1;
      end
    end else if (sweep_last_i) begin
      mask_q <= '0;
    end
  end

  // Data storage: plain register file, no reset needed.
  always_ff @(posedge clk) begin
    if (do_byte) data_q[off_q] <= byte_i;
  end

  // Registered write port fed by the commit sweep.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o    <= sweep_en_i && mask_q[sweep_idx_i];
      mem_addr_o  <= {page_q, sweep_idx_i};
      mem_wdata_o <= data_q[sweep_idx_i];
    end
  end

  assign mask_any_o = |mask_q;

  // R9: session state is frozen while a cycle runs (mask only clears at sweep end)
  p_page_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(page_q) && $stable(off_q));
  // R8: an accepted abort empties the mask
  p_abort_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (abort_i && idle) |=> (mask_q == '0));
  // R10: the write strobe is confined to the busy window
  p_we_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_i);
  // R4: the session mask is empty again once the cycle ends
  p_mask_done_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_i) |-> (mask_q == '0));
  // R3: a data byte always moves the offset forward by one, modulo the page
  p_off_step_r3: assert property (@(posedge clk) disable iff (rst)
    do_byte |=> (off_q == IDX_W'($past(off_q) + 1'b1)));

endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
  import pgwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  byte_t             wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output byte_t             rdata_o
);

  byte_t mem [DEPTH];

  // Erased state of every location.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // R6: write address is always defined when a write happens
  always_ff @(posedge clk) begin
    if (we_i) a_waddr_known_r6: assert (!$isunknown(waddr_i));
  end

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
  import pgwr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned WR_CYCLES  = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              abort_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              busy_o
);

  localparam int unsigned IDX_W = $clog2(PAGE_BYTES);

  logic             busy;
  logic             mask_any;
  logic             start;
  logic             sweep_en;
  logic             sweep_last;
  logic [IDX_W-1:0] sweep_idx;

  assign start = commit_i && !abort_i && mask_any && !busy;

  pgwr_timer #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .busy_o      (busy),
    .sweep_en_o  (sweep_en),
    .sweep_idx_o (sweep_idx),
    .sweep_last_o(sweep_last)
  );

  pgwr_buffer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk         (clk),
    .rst         (rst),
    .busy_i      (busy),
    .abort_i     (abort_i),
    .commit_i    (commit_i),
    .addr_load_i (addr_load_i),
    .addr_i      (addr_i),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .sweep_en_i  (sweep_en),
    .sweep_idx_i (sweep_idx),
    .sweep_last_i(sweep_last),
    .mask_any_o  (mask_any),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  pgwr_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk    (clk),
    .we_i   (mem_we_o),
    .waddr_i(mem_addr_o),
    .wdata_i(mem_wdata_o),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  assign busy_o = busy;

  // R7: a commit with an empty buffer does not start a cycle
  p_empty_commit_r7: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !mask_any && !busy) |=> !busy);
  // R1: reset leaves the block idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !mem_we_o));

endmodule

// File: tb/sim_pgwr_engine.sv
module sim_pgwr_engine;

  localparam int AW  = 8;
  localparam int PB  = 32;
  localparam int WRC = 40;
  localparam int EFF = (WRC < PB + 2) ? PB + 2 : WRC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_load_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          byte_valid_i = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          abort_i = 1'b0;
  logic          commit_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    rd_data_o;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o;
  logic          busy_o;

  always #2.5 clk = ~clk;

  pgwr_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .abort_i(abort_i),
    .commit_i(commit_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .busy_o(busy_o));

  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  bit done = 0;

  logic [7:0] model [1<<AW];
  logic [7:0] pend_d [PB];
  logic       pend_m [PB];

  // Session table: {start address, byte count, first data value}
  localparam int NV = 5;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'd1,  8'h11},   // single byte
    {8'h25, 8'd4,  8'h40},   // mid-page run
    {8'h3E, 8'd4,  8'h50},   // crosses page top, wraps
    {8'h60, 8'd32, 8'h80},   // full page
    {8'h8A, 8'd35, 8'hA0}    // longer than page, overwrites
  };

  always @(negedge clk) if (mem_we_o === 1'b1) we_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_addr(input logic [AW-1:0] a);
    addr_i = a; addr_load_i = 1'b1; tick(); addr_load_i = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b);
    byte_i = b; byte_valid_i = 1'b1; tick(); byte_valid_i = 1'b0;
  endtask

  task automatic do_stop(); commit_i = 1'b1; tick(); commit_i = 1'b0; endtask
  task automatic do_abort(); abort_i = 1'b1; tick(); abort_i = 1'b0; endtask

  task automatic wait_idle(); while (busy_o) tick(); endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_addr_i = a; tick(); d = rd_data_o;
  endtask

  task automatic compare_all(input string req);
    logic [7:0] d;
    for (int i = 0; i < (1<<AW); i++) begin
      rd(AW'(i), d);
      chk(req, {24'h0, d}, {24'h0, model[i]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    for (int i = 0; i < (1<<AW); i++) model[i] = 8'hFF;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: idle after reset
    chk("R1 busy", {31'h0, busy_o}, 32'h0);
    chk("R1 we", {31'h0, mem_we_o}, 32'h0);
    // R6: erased content and one-cycle read
    rd(8'h33, d); chk("R6 erased", {24'h0, d}, 32'hFF);
    rd(8'hF0, d); chk("R6 erased", {24'h0, d}, 32'hFF);

    // Table walk: R2, R3, R4, R5, R10
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      int cnt;
      int distinct;
      logic [7:0] first;
      a = VEC[v][23:16]; cnt = int'(VEC[v][15:8]); first = VEC[v][7:0];
      for (int k = 0; k < PB; k++) pend_m[k] = 1'b0;
      do_addr(a);
      for (int k = 0; k < cnt; k++) begin
        int off;
        off = (int'(a[4:0]) + k) % PB;
        pend_d[off] = first + 8'(k);
        pend_m[off] = 1'b1;
        do_byte(first + 8'(k));
      end
      distinct = 0;
      for (int k = 0; k < PB; k++) if (pend_m[k]) begin
        model[{a[AW-1:5], 5'(k)}] = pend_d[k];
        distinct++;
      end
      we_cnt = 0;
      do_stop();
      chk("R5 busy rises", {31'h0, busy_o}, 32'h1);
      n = 0;
      while (busy_o) begin n++; tick(); end
      chk("R5 busy length", n, EFF);
      chk("R4 write count", we_cnt, distinct);
      // R10: reads right after busy falls must show new data
      compare_all("R2/R3/R4/R10 array");
    end

    // R7: commit with nothing loaded
    we_cnt = 0;
    do_stop();
    chk("R7 no busy", {31'h0, busy_o}, 32'h0);
    repeat (PB + 4) tick();
    chk("R7 no writes", we_cnt, 0);

    // R8: abort discards the session
    do_addr(8'hC0);
    do_byte(8'h5A); do_byte(8'h5B); do_byte(8'h5C);
    do_abort();
    we_cnt = 0;
    do_stop();
    chk("R8 no busy after abort", {31'h0, busy_o}, 32'h0);
    repeat (PB + 4) tick();
    chk("R8 no writes after abort", we_cnt, 0);
    rd(8'hC0, d); chk("R8 byte unchanged", {24'h0, d}, 32'hFF);

    // R8: abort wins over a same-cycle commit
    do_addr(8'hC8); do_byte(8'h66);
    abort_i = 1'b1; commit_i = 1'b1; tick(); abort_i = 1'b0; commit_i = 1'b0;
    chk("R8 abort priority", {31'h0, busy_o}, 32'h0);

    // R9: strobes during busy are ignored
    do_addr(8'hE0); do_byte(8'h12);
    model[8'hE0] = 8'h12;
    do_stop();
    chk("R9 busy", {31'h0, busy_o}, 32'h1);
    do_addr(8'hE5);
    do_byte(8'h77); do_byte(8'h78);
    do_stop();
    do_abort();
    wait_idle();
    rd(8'hE0, d); chk("R9 committed byte", {24'h0, d}, 32'h12);
    rd(8'hE5, d); chk("R9 busy byte ignored", {24'h0, d}, 32'hFF);
    rd(8'hE6, d); chk("R9 busy byte ignored", {24'h0, d}, 32'hFF);
    we_cnt = 0;
    do_stop();
    chk("R9 nothing buffered", {31'h0, busy_o}, 32'h0);
    repeat (PB + 4) tick();
    chk("R9 no late writes", we_cnt, 0);
    compare_all("R9 array");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule